// File: doc/BRIEF.md
# Block-Store Word Address Sequencer

The sequencer turns a single block-store request into a series of word writes, one for each register whose bit is set in a 16-bit selection mask. A request gives a word-aligned base address, the index of the register that holds that base, the selection mask, and two mode bits. The `req_pre` bit chooses whether the address moves before or after each word. The `req_up` bit chooses whether the block lies above or below the base. Whatever the mode, the selected registers go out in ascending index order, and the lowest index is stored at the lowest address.

For each write the block presents the register index to read, the word address, and a write strobe. It holds all three until `mem_ready` is high on a clock edge together with the strobe. The register index always refers to the unprivileged bank. The block flags this on `wr_user_bank` so that the register file reads the user copies and not the banked ones. The base register is never written back. The block has no path for doing so.

Some requests are malformed: the base index is the program counter (index 15), or the mask is empty. Such a request produces no writes and a one-cycle `done` together with `err`. A request is taken only when no transfer is in progress.

Top module: `stm_addr_seq`

## Requirements
- R1: With `req_pre`=0 and `req_up`=1 (ascending, post-step), the first write goes to `req_base` and each later write goes to the next word address up.
- R2: With `req_pre`=1 and `req_up`=1 (ascending, pre-step), the first write goes to `req_base`+4.
- R3: With `req_pre`=0 and `req_up`=0 (descending, post-step), the last write goes to `req_base`, so the first write goes to `req_base`−4·N+4, where N is the number of set mask bits.
- R4: With `req_pre`=1 and `req_up`=0 (descending, pre-step), the last write goes to `req_base`−4, so the first write goes to `req_base`−4·N.
- R5: `wr_reg` steps through the set bits of the mask from lowest to highest. Each accepted write moves `wr_addr` up by exactly 4, with address arithmetic modulo 2^32.
- R6: Exactly N writes are accepted for a valid request.
- R7: While `wr_en` is high and `mem_ready` is low, `wr_en`, `wr_reg` and `wr_addr` hold their values.
- R8: A request with base index 15 issues no write. In the cycle after it is accepted, `done` and `err` are high together.
- R9: A request with an all-zero mask issues no write. In the cycle after it is accepted, `done` and `err` are high together.
- R10: A request presented while `wr_en` is high is ignored. The transfer in progress is unchanged, and no write or error follows from the ignored request.
- R11: In the cycle after the last accepted write, `done` is high for one cycle with `err` low and `wr_en` low.
- R12: `wr_user_bank` is high whenever `wr_en` is high.
- R13: After reset, `wr_en`, `done` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when `wr_en` is low |
| req_base | input | 32 | Base word address |
| req_base_idx | input | 4 | Index of the register holding the base |
| req_mask | input | 16 | Register selection mask, bit i selects register i |
| req_pre | input | 1 | 1: step before each word, 0: step after |
| req_up | input | 1 | 1: block above base, 0: block below base |
| mem_ready | input | 1 | Memory accepts the presented write on this edge |
| wr_en | output | 1 | Write strobe; also marks the block busy |
| wr_reg | output | 4 | Register index to read for this write |
| wr_addr | output | 32 | Word address of this write |
| wr_user_bank | output | 1 | Read `wr_reg` from the unprivileged bank |
| done | output | 1 | One-cycle end-of-request pulse |
| err | output | 1 | Request was invalid (with `done`) |

## Verification
The hardest situation to reach is a new request arriving while a transfer is stalled or about to finish. The block must ignore that request, even when it is itself invalid or uses a different mode. The sweep reaches this by driving a different, conflicting request on every other cycle of each transfer, including the cycle of the final handshake. At the same time it holds `mem_ready` low in periodic patterns. The descending modes are also run from base addresses near zero, so that the lowest address wraps around 2^32.

// File: rtl/stm_addr_seq.sv
module stm_addr_seq #(
  parameter int NREG = 16,
  parameter int AW   = 32,
  parameter int WB   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [AW-1:0]            req_base,
  input  logic [$clog2(NREG)-1:0]  req_base_idx,
  input  logic [NREG-1:0]          req_mask,
  input  logic                     req_pre,
  input  logic                     req_up,
  input  logic                     mem_ready,
  output logic                     wr_en,
  output logic [$clog2(NREG)-1:0]  wr_reg,
  output logic [AW-1:0]            wr_addr,
  output logic                     wr_user_bank,
  output logic                     done,
  output logic                     err
);
  localparam int IW = $clog2(NREG);

  logic [NREG-1:0] pend;
  logic [AW-1:0]   addr_q, span, first_addr;
  logic            done_q, err_q;

  wire bad_req = (req_base_idx == IW'(NREG - 1)) || (req_mask == '0);
  wire accept  = req_valid && !wr_en;
  wire step    = wr_en && mem_ready;
  wire [NREG-1:0] pend_nxt = pend & (pend - 1'b1);

  assign span = AW'($countones(req_mask)) * AW'(WB);

  always_comb begin
    case ({req_pre, req_up})
      2'b01:   first_addr = req_base;
      2'b11:   first_addr = req_base + AW'(WB);
      2'b00:   first_addr = req_base - span + AW'(WB);
      default: first_addr = req_base - span;
    endcase
  end

  always_comb begin
    wr_reg = '0;
    for (int i = NREG - 1; i >= 0; i--)
      if (pend[i]) wr_reg = IW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend   <= '0;
      addr_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (accept) begin
        if (bad_req) begin
          done_q <= 1'b1;
          err_q  <= 1'b1;
        end else begin
          pend   <= req_mask;
          addr_q <= first_addr;
        end
      end else if (step) begin
        pend   <= pend_nxt;
        addr_q <= addr_q + AW'(WB);
        if (pend_nxt == '0) done_q <= 1'b1;
      end
    end
  end

  assign wr_en        = |pend;
  assign wr_addr      = addr_q;
  assign wr_user_bank = wr_en;
  assign done         = done_q;
  assign err          = err_q;
endmodule

// File: rtl/stm_addr_seq_chk.sv
module stm_addr_seq_chk #(
  parameter int NREG = 16,
  parameter int AW   = 32,
  parameter int WB   = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    mem_ready,
  input logic                    wr_en,
  input logic [$clog2(NREG)-1:0] wr_reg,
  input logic [AW-1:0]           wr_addr,
  input logic                    done,
  input logic                    err
);
  a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && mem_ready) |=> (!wr_en || wr_addr == $past(wr_addr) + AW'(WB)));

  a_r5_reg_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && mem_ready) |=> (!wr_en || wr_reg > $past(wr_reg)));

  a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !mem_ready) |=> (wr_en && $stable(wr_addr) && $stable(wr_reg)));

  a_r8_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wr_en);

  a_r10_no_err_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !err);
endmodule

bind stm_addr_seq stm_addr_seq_chk #(.NREG(NREG), .AW(AW), .WB(WB)) chk_i (
  .clk(clk), .rst_n(rst_n), .mem_ready(mem_ready), .wr_en(wr_en),
  .wr_reg(wr_reg), .wr_addr(wr_addr), .done(done), .err(err)
);

// File: tb/stm_addr_seq_tb.sv
module stm_addr_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_base = '0;
  logic [3:0]  req_base_idx = '0;
  logic [15:0] req_mask = '0;
  logic        req_pre = 1'b0, req_up = 1'b0, mem_ready = 1'b0;
  logic        wr_en, wr_user_bank, done, err;
  logic [3:0]  wr_reg;
  logic [31:0] wr_addr;
  int total = 0, bad = 0, cyc = 0;

  always #4 clk = ~clk;

  stm_addr_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_base(req_base),
    .req_base_idx(req_base_idx), .req_mask(req_mask), .req_pre(req_pre),
    .req_up(req_up), .mem_ready(mem_ready), .wr_en(wr_en), .wr_reg(wr_reg),
    .wr_addr(wr_addr), .wr_user_bank(wr_user_bank), .done(done), .err(err)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog: act=%0d exp<=150000 cycles", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] base, input logic [3:0] idx,
                     input logic [15:0] mask, input bit p, input bit u, input int st);
    int cnt, k, c;
    logic [31:0] low, ea;
    logic [15:0] rem;
    logic [3:0]  er;
    string mt;
    bit rdy;
    cnt = $countones(mask);
    case ({p, u})
      2'b01: begin low = base;                         mt = "R1"; end
      2'b11: begin low = base + 32'd4;                 mt = "R2"; end
      2'b00: begin low = base - 32'(4 * cnt) + 32'd4;  mt = "R3"; end
      default: begin low = base - 32'(4 * cnt);        mt = "R4"; end
    endcase
    @(negedge clk);
    req_valid = 1'b1; req_base = base; req_base_idx = idx;
    req_mask = mask; req_pre = p; req_up = u;
    @(negedge clk);
    k = 0; c = 0; rem = mask;
    while (k < cnt && c < 400) begin
      er = '0;
      for (int i = 15; i >= 0; i--) if (rem[i]) er = 4'(i);
      ea = low + 32'(4 * k);
      rdy = (st == 0) || (c % st != 0);
      mem_ready = rdy;
      req_valid = (c % 2 == 1);
      req_base = ~base; req_base_idx = (c % 4 == 1) ? 4'd15 : 4'd0;
      req_mask = (c % 4 == 3) ? 16'h0 : 16'h0001;
      req_pre = ~p; req_up = ~u;
      chk(wr_en && wr_user_bank, "R12", "strobe/bank", {30'd0, wr_en, wr_user_bank}, 32'd3);
      if (rdy) begin
        chk(wr_addr == ea, mt, "addr", wr_addr, ea);
        chk(wr_reg == er, "R5", "reg", 32'(wr_reg), 32'(er));
        rem = rem & (rem - 16'd1);
        k++;
      end else begin
        chk(wr_addr == ea && wr_reg == er, "R7", "held addr", wr_addr, ea);
      end
      @(negedge clk);
      c++;
    end
    mem_ready = 1'b0; req_valid = 1'b0;
    chk(k == cnt, "R6", "write count", 32'(k), 32'(cnt));
    chk(done && !err && !wr_en, "R11", "done pulse", {29'd0, done, err, wr_en}, 32'd4);
    @(negedge clk);
    chk(!done && !err && !wr_en, "R10", "idle after", {29'd0, done, err, wr_en}, 32'd0);
  endtask

  task automatic run_bad(input logic [31:0] base, input logic [3:0] idx,
                         input logic [15:0] mask, input bit p, input bit u, input string rq);
    @(negedge clk);
    req_valid = 1'b1; req_base = base; req_base_idx = idx;
    req_mask = mask; req_pre = p; req_up = u;
    @(negedge clk);
    req_valid = 1'b0;
    chk(done && err && !wr_en, rq, "invalid flag", {29'd0, done, err, wr_en}, 32'd6);
    @(negedge clk);
    chk(!done && !err && !wr_en, rq, "no writes", {29'd0, done, err, wr_en}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!wr_en && !done && !err, "R13", "reset", {29'd0, wr_en, done, err}, 32'd0);
    rst_n = 1'b1;
    for (int j = 0; j < 40; j++) begin
      logic [15:0] m;
      int st;
      m = (j < 16) ? 16'(1 << j) : (j < 32) ? (16'hFFFF >> (j - 16))
                                            : 16'(32'h9249 << (j - 32));
      st = (j % 3 == 0) ? 0 : (j % 3) + 1;
      for (int md = 0; md < 4; md++) begin
        logic [31:0] b;
        b = (j % 8 == 0) ? 32'd4 : (32'h0000_1000 + 32'(j * 36)) & ~32'd3;
        run(b, 4'(j % 15), m, md[1], md[0], st);
      end
    end
    for (int md = 0; md < 4; md++) begin
      run_bad(32'h200, 4'd15, 16'h00F0, md[1], md[0], "R8");
      run_bad(32'h200, 4'd3, 16'h0000, md[1], md[0], "R9");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule